// File: doc/BRIEF.md
# Torus Systolic Matrix Multiplier

This block computes the accumulating product C = C + A×B on square integer matrices with an N-by-N grid of multiply-accumulate cells. Each cell links to its east and south neighbours, and the links wrap around at the grid edges, so the grid forms a torus. A run-time mode picks which matrix stays inside the cells while the other two circulate. A C-resident job streams A westward and B northward. An A-resident job keeps A in place and moves B north and the running sums west. A B-resident job keeps B in place and moves A west and the running sums north.

A job begins with a one-cycle start pulse. The host then streams N rows of A, N rows of B and N rows of C through one row-wide input port, one row per strobed cycle. Each row is placed directly at its pre-aligned (skewed) position in the grid, so compute can begin as soon as the last row arrives. Compute lasts N clock steps. The grid then returns the N rows of the result in order, and a one-cycle done pulse closes the job.

Top module: `torus_mmac`

## Requirements
- R1: While reset is active and on the first cycle after it is released, busy, out_valid and done are all low.
- R2: After a start is accepted, the first N cycles with in_valid high carry the rows of A, the next N the rows of B, and the next N the rows of C, each in row order 0 to N-1. Cycles with in_valid low are skipped. Lane x of in_row (bits x*AW upward) holds column x. For A and B only the low DW bits of each lane are used, read as signed.
- R3: With mode 2'b00 (C resident) or 2'b11 (handled the same way), each result entry equals C[i][j] plus the sum over k of A[i][k]·B[k][j], with signed DW-bit operands and an AW-bit sum that wraps modulo 2^AW.
- R4: With mode 2'b01 (A resident), the result is the same value as in R3.
- R5: With mode 2'b10 (B resident), the result is the same value as in R3.
- R6: The first result row appears exactly N+1 clock cycles after the clock edge that accepted the last row of C.
- R7: out_valid is high for exactly N consecutive cycles per job, and out_row carries result row r on the r-th of those cycles.
- R8: done is high for one cycle, on the cycle right after the last result row, and busy is low in that cycle.
- R9: A start pulse while busy is ignored and does not change the mode of the running job. in_valid outside the three load phases is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a job when the block is idle |
| mode | input | 2 | Resident matrix: 00 C, 01 A, 10 B, 11 C |
| in_valid | input | 1 | Marks in_row as a load row |
| in_row | input | N*AW | One matrix row, lane x is column x |
| busy | output | 1 | A job is in progress |
| out_valid | output | 1 | out_row holds a result row |
| out_row | output | N*AW | One result row, lane x is column x |
| done | output | 1 | One-cycle end-of-job pulse |

## Verification
Two pairs of events can collide. A start pulse and stray load strobes can arrive while the grid is shifting operands. The final result row and the done pulse are adjacent, and the next job could begin right behind them. The bench holds start and in_valid high with junk data and a different mode through every compute step. It then checks that the results still match a behavioural sum-of-products model, that exactly N rows come out, and that busy stays low afterwards instead of starting a second job. The timing of the first row against the last load edge, and of done against the last row, is judged by a free-running cycle counter.

// File: rtl/torus_mmac_pkg.sv
package torus_mmac_pkg;

   typedef enum logic [1:0] {KEEP_C = 2'b00, KEEP_A = 2'b01, KEEP_B = 2'b10} stat_e;
   typedef enum logic [1:0] {MAT_A = 2'b00, MAT_B = 2'b01, MAT_C = 2'b10} mat_e;
   typedef enum logic [2:0] {
      S_IDLE, S_LDA, S_LDB, S_LDC, S_STEP, S_DRAIN, S_FIN
   } seq_e;

   function automatic stat_e norm_mode(input logic [1:0] m);
      case (m)
         2'b01:   return KEEP_A;
         2'b10:   return KEEP_B;
         default: return KEEP_C;
      endcase
   endfunction

   // Is cell (p,q) the target of some lane when row r of matrix t is loaded?
   function automatic logic lane_hit(input stat_e m, input mat_e t,
                                     input int p, input int q, input int r, input int n);
      logic on_row, on_col, on_diag;
      on_row  = (p == r);
      on_col  = (q == r);
      on_diag = (((p + q) % n) == r);
      case (t)
         MAT_A:   return (m == KEEP_B) ? on_diag : on_row;
         MAT_B:   return (m == KEEP_C) ? on_diag : ((m == KEEP_A) ? on_col : on_row);
         default: return (m == KEEP_B) ? on_diag : on_row;
      endcase
   endfunction

   // Which input lane feeds cell (p,q) in a load of matrix t.
   function automatic int lane_src(input stat_e m, input mat_e t,
                                   input int p, input int q, input int n);
      case (t)
         MAT_A:   return (m == KEEP_C) ? (p + q) % n : ((m == KEEP_A) ? q : p);
         MAT_B:   return (m == KEEP_A) ? (p + q) % n : q;
         default: return (m == KEEP_A) ? (p + q) % n : q;
      endcase
   endfunction

   // Grid position that holds result entry (r,x) after the run.
   function automatic int home_row(input stat_e m, input int r, input int x, input int n);
      return (m == KEEP_B) ? (r - x + n) % n : r;
   endfunction

   function automatic int home_col(input stat_e m, input int r, input int x, input int n);
      return (m == KEEP_A) ? (x - r + n) % n : x;
   endfunction

endpackage

// File: rtl/torus_mmac_pe.sv
module torus_mmac_pe
   import torus_mmac_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  stat_e                mode,
   input  logic                 step,
   input  logic                 ld_a,
   input  logic                 ld_b,
   input  logic                 ld_c,
   input  logic [AW-1:0]        ld_val,
   input  logic signed [DW-1:0] a_east,
   input  logic signed [DW-1:0] b_south,
   input  logic [AW-1:0]        sum_east,
   input  logic [AW-1:0]        sum_south,
   output logic signed [DW-1:0] a_q,
   output logic signed [DW-1:0] b_q,
   output logic [AW-1:0]        c_q,
   output logic [AW-1:0]        sum_q
);

   logic signed [AW-1:0] a_x;
   logic signed [AW-1:0] b_x;
   logic signed [AW-1:0] prod;

   assign a_x   = AW'(a_q);
   assign b_x   = AW'(b_q);
   assign prod  = a_x * b_x;
   assign sum_q = c_q + prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_q <= '0;
         b_q <= '0;
         c_q <= '0;
      end else begin
         if (ld_a)
            a_q <= ld_val[DW-1:0];
         else if (step && mode != KEEP_A)
            a_q <= a_east;

         if (ld_b)
            b_q <= ld_val[DW-1:0];
         else if (step && mode != KEEP_B)
            b_q <= b_south;

         if (ld_c)
            c_q <= ld_val;
         else if (step) begin
            case (mode)
               KEEP_C:  c_q <= sum_q;
               KEEP_A:  c_q <= sum_east;
               default: c_q <= sum_south;
            endcase
         end
      end
   end

endmodule

// File: rtl/torus_mmac_seq.sv
module torus_mmac_seq
   import torus_mmac_pkg::*;
#(
   parameter int N  = 4,
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    mode_in,
   input  logic          in_valid,
   output stat_e         mode_q,
   output logic          ld_en,
   output mat_e          ld_mat,
   output logic          step,
   output logic          drain,
   output logic          fin,
   output logic [CW-1:0] row,
   output logic          busy
);

   localparam logic [CW-1:0] LAST = CW'(N - 1);

   seq_e state;
   logic at_last;

   assign at_last = (row == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         row    <= '0;
         mode_q <= KEEP_C;
      end else begin
         case (state)
            S_IDLE: if (start) begin
               state  <= S_LDA;
               row    <= '0;
               mode_q <= norm_mode(mode_in);
            end
            S_LDA, S_LDB, S_LDC: if (in_valid) begin
               if (at_last) begin
                  row   <= '0;
                  state <= (state == S_LDA) ? S_LDB :
                           (state == S_LDB) ? S_LDC : S_STEP;
               end else begin
                  row <= row + 1'b1;
               end
            end
            S_STEP, S_DRAIN: begin
               if (at_last) begin
                  row   <= '0;
                  state <= (state == S_STEP) ? S_DRAIN : S_FIN;
               end else begin
                  row <= row + 1'b1;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign ld_en  = in_valid && (state == S_LDA || state == S_LDB || state == S_LDC);
   assign ld_mat = (state == S_LDA) ? MAT_A : ((state == S_LDB) ? MAT_B : MAT_C);
   assign step   = (state == S_STEP);
   assign drain  = (state == S_DRAIN);
   assign fin    = (state == S_FIN);
   assign busy   = (state != S_IDLE);

endmodule

// File: rtl/torus_mmac_rowsel.sv
module torus_mmac_rowsel
   import torus_mmac_pkg::*;
#(
   parameter int N  = 4,
   parameter int AW = 32,
   parameter int CW = 2
) (
   input  stat_e              mode,
   input  logic [CW-1:0]      row,
   input  logic [N*N*AW-1:0]  grid,
   output logic [N*AW-1:0]    row_out
);

   always_comb begin
      for (int x = 0; x < N; x++) begin
         row_out[x*AW +: AW] =
            grid[(home_row(mode, int'(row), x, N) * N +
                  home_col(mode, int'(row), x, N)) * AW +: AW];
      end
   end

endmodule

// File: rtl/torus_mmac.sv
module torus_mmac
   import torus_mmac_pkg::*;
#(
   parameter int N  = 4,
   parameter int DW = 16,
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [1:0]    mode,
   input  logic          in_valid,
   input  logic [N*AW-1:0] in_row,
   output logic          busy,
   output logic          out_valid,
   output logic [N*AW-1:0] out_row,
   output logic          done
);

   localparam int CW = (N > 1) ? $clog2(N) : 1;
   localparam int GW = N * N * AW;

   if (N < 2) begin : g_bad_n
      $error("torus_mmac: N must be at least 2");
   end
   if (AW < 2 * DW) begin : g_bad_aw
      $error("torus_mmac: AW must hold a full DW x DW product");
   end

   stat_e         mode_q;
   mat_e          ld_mat;
   logic          ld_en;
   logic          step_w;
   logic          drain;
   logic          fin;
   logic [CW-1:0] row;
   logic [GW-1:0] c_flat;
   logic [N*AW-1:0] sel_row;

   logic signed [DW-1:0] a_g   [N][N];
   logic signed [DW-1:0] b_g   [N][N];
   logic [AW-1:0]        c_g   [N][N];
   logic [AW-1:0]        sum_g [N][N];

   torus_mmac_seq #(.N(N), .CW(CW)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
      .in_valid(in_valid), .mode_q(mode_q), .ld_en(ld_en), .ld_mat(ld_mat),
      .step(step_w), .drain(drain), .fin(fin), .row(row), .busy(busy)
   );

   for (genvar p = 0; p < N; p++) begin : g_row
      for (genvar q = 0; q < N; q++) begin : g_col
         localparam int EQ = (q + 1) % N;
         localparam int SP = (p + 1) % N;
         logic          hit;
         logic [AW-1:0] val;

         always_comb begin
            hit = ld_en && lane_hit(mode_q, ld_mat, p, q, int'(row), N);
            val = in_row[lane_src(mode_q, ld_mat, p, q, N) * AW +: AW];
         end

         torus_mmac_pe #(.DW(DW), .AW(AW)) pe_i (
            .clk(clk), .rst_n(rst_n), .mode(mode_q), .step(step_w),
            .ld_a(hit && ld_mat == MAT_A),
            .ld_b(hit && ld_mat == MAT_B),
            .ld_c(hit && ld_mat == MAT_C),
            .ld_val(val),
            .a_east(a_g[p][EQ]), .b_south(b_g[SP][q]),
            .sum_east(sum_g[p][EQ]), .sum_south(sum_g[SP][q]),
            .a_q(a_g[p][q]), .b_q(b_g[p][q]), .c_q(c_g[p][q]), .sum_q(sum_g[p][q])
         );

         assign c_flat[(p*N + q)*AW +: AW] = c_g[p][q];
      end
   end

   torus_mmac_rowsel #(.N(N), .AW(AW), .CW(CW)) rowsel_i (
      .mode(mode_q), .row(row), .grid(c_flat), .row_out(sel_row)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_row   <= '0;
         done      <= 1'b0;
      end else begin
         out_valid <= drain;
         done      <= fin;
         if (drain)
            out_row <= sel_row;
      end
   end

endmodule

// File: rtl/torus_mmac_chk.sv
module torus_mmac_chk
   import torus_mmac_pkg::*;
#(
   parameter int N = 4
) (
   input logic  clk,
   input logic  rst_n,
   input logic  busy,
   input logic  out_valid,
   input logic  done,
   input logic  step,
   input stat_e mode_q
);

   int   step_run;
   int   ov_run;
   logic step_d;
   logic ov_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_run <= 0;
         ov_run   <= 0;
         step_d   <= 1'b0;
         ov_d     <= 1'b0;
      end else begin
         step_d <= step;
         ov_d   <= out_valid;
         if (step && !step_d)  step_run <= 1;
         else if (step)        step_run <= step_run + 1;
         if (out_valid && !ov_d) ov_run <= 1;
         else if (out_valid)     ov_run <= ov_run + 1;
      end
   end

   // R1
   idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!busy && !out_valid && !done));

   // R6
   step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> (step_run == N));

   // R7
   row_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> (ov_run == N));

   // R7
   rows_inside_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> busy);

   // R8
   done_after_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_valid) |-> done);

   // R8
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9
   mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mode_q));

endmodule

bind torus_mmac torus_mmac_chk #(.N(N)) chk_i (
   .clk(clk), .rst_n(rst_n), .busy(busy), .out_valid(out_valid),
   .done(done), .step(step_w), .mode_q(mode_q)
);

// File: tb/torus_mmac_tb_top.sv
module torus_mmac_tb_top;

   localparam int N  = 4;
   localparam int DW = 16;
   localparam int AW = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [1:0]      mode = 2'b00;
   logic            in_valid = 1'b0;
   logic [N*AW-1:0] in_row = '0;
   logic            busy;
   logic            out_valid;
   logic [N*AW-1:0] out_row;
   logic            done;

   always #10 clk = ~clk;

   torus_mmac #(.N(N), .DW(DW), .AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .in_valid(in_valid), .in_row(in_row), .busy(busy),
      .out_valid(out_valid), .out_row(out_row), .done(done)
   );

   int tests = 0;
   int fails = 0;
   int cyc   = 0;
   int last_acc = 0;
   int rows_seen = 0;
   bit first_row = 1'b0;
   bit done_seen = 1'b0;
   bit expecting = 1'b0;
   logic prev_ov = 1'b0;
   string cur_tag = "R3";

   logic signed [DW-1:0] ma [N][N];
   logic signed [DW-1:0] mb [N][N];
   logic [AW-1:0]        mc [N][N];
   logic [N*AW-1:0]      exp_q [$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic report;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired (actual running, expected finished)");
      report();
   end

   // Reference comparison on every falling edge.
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            tests++;
            if (exp_q.size() == 0) begin
               fails++;
               $display("FAIL R7 unexpected row: actual %h expected none", out_row);
            end else begin
               logic [N*AW-1:0] e;
               e = exp_q.pop_front();
               if (out_row !== e) begin
                  fails++;
                  $display("FAIL %s row %0d: actual %h expected %h", cur_tag, rows_seen, out_row, e);
               end
               if (rows_seen > 0 && !prev_ov) begin
                  fails++;
                  $display("FAIL R7 gap in rows: actual out_valid 0 expected 1 before row %0d", rows_seen);
               end
            end
            if (first_row) begin
               tests++;
               first_row = 1'b0;
               if (cyc - last_acc != N + 1) begin
                  fails++;
                  $display("FAIL R6 latency: actual %0d expected %0d", cyc - last_acc, N + 1);
               end
            end
            rows_seen++;
         end
         if (done) begin
            tests++;
            if (!expecting || !prev_ov || rows_seen != N || busy) begin
               fails++;
               $display("FAIL R8 done: actual rows %0d prev_ov %0b busy %0b expected rows %0d prev_ov 1 busy 0",
                        rows_seen, prev_ov, busy, N);
            end
            done_seen = 1'b1;
            expecting = 1'b0;
         end
         prev_ov = out_valid;
      end
   end

   task automatic fill_random;
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            ma[i][j] = DW'($urandom);
            mb[i][j] = DW'($urandom);
            mc[i][j] = $urandom;
         end
   endtask

   task automatic build_expected;
      exp_q.delete();
      for (int r = 0; r < N; r++) begin
         logic [N*AW-1:0] v;
         for (int x = 0; x < N; x++) begin
            logic signed [AW-1:0] acc;
            logic signed [AW-1:0] ea;
            logic signed [AW-1:0] eb;
            acc = mc[r][x];
            for (int k = 0; k < N; k++) begin
               ea  = ma[r][k];
               eb  = mb[k][x];
               acc = acc + ea * eb;
            end
            v[x*AW +: AW] = acc;
         end
         exp_q.push_back(v);
      end
   endtask

   task automatic run_job(input logic [1:0] m, input bit gaps, input bit noise, input string tag);
      build_expected();
      cur_tag   = tag;
      rows_seen = 0;
      first_row = 1'b1;
      done_seen = 1'b0;
      expecting = 1'b1;
      @(posedge clk); #2;
      start = 1'b1; mode = m;
      @(posedge clk); #2;
      start = 1'b0;
      // R2: A rows, then B rows, then C rows
      for (int ph = 0; ph < 3; ph++) begin
         for (int r = 0; r < N; r++) begin
            if (gaps && (r % 2 == 0)) begin
               in_valid = 1'b0;
               in_row = {N{$urandom}};
               @(posedge clk); #2;
            end
            for (int x = 0; x < N; x++) begin
               if (ph == 0)      in_row[x*AW +: AW] = {16'($urandom), ma[r][x]};
               else if (ph == 1) in_row[x*AW +: AW] = {16'($urandom), mb[r][x]};
               else              in_row[x*AW +: AW] = mc[r][x];
            end
            in_valid = 1'b1;
            @(posedge clk); #2;
         end
      end
      in_valid = 1'b0;
      last_acc = cyc;
      if (noise) begin
         // R9: start and strobes while the grid is shifting
         for (int i = 0; i < N; i++) begin
            start = 1'b1; mode = ~m; in_valid = 1'b1;
            in_row = {N{$urandom}};
            @(posedge clk); #2;
         end
         start = 1'b0; in_valid = 1'b0;
      end
      while (!done_seen) @(posedge clk);
      repeat (3) @(posedge clk);
      #2;
      tests++;
      if (busy || out_valid || exp_q.size() != 0) begin
         fails++;
         $display("FAIL R9 after job: actual busy %0b out_valid %0b left %0d expected 0 0 0",
                  busy, out_valid, exp_q.size());
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs idle while in reset
      tests++;
      if (busy || out_valid || done) begin
         fails++;
         $display("FAIL R1 in reset: actual %0b%0b%0b expected 000", busy, out_valid, done);
      end
      #3 rst_n = 1'b1;
      @(negedge clk);
      tests++;
      if (busy || out_valid || done) begin
         fails++;
         $display("FAIL R1 after reset: actual %0b%0b%0b expected 000", busy, out_valid, done);
      end

      fill_random(); run_job(2'b00, 1'b0, 1'b0, "R3");
      fill_random(); run_job(2'b01, 1'b0, 1'b0, "R4");
      fill_random(); run_job(2'b10, 1'b0, 1'b0, "R5");
      fill_random(); run_job(2'b11, 1'b0, 1'b0, "R3");
      fill_random(); run_job(2'b01, 1'b1, 1'b0, "R2");
      fill_random(); run_job(2'b10, 1'b1, 1'b1, "R9");
      fill_random(); run_job(2'b00, 1'b0, 1'b1, "R9");

      // R3 wrap: every product is 2^30, so each column sum overflows
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            ma[i][j] = 16'sh8000;
            mb[i][j] = 16'sh8000;
            mc[i][j] = 32'h7fff_ffff - 32'(i + j);
         end
      run_job(2'b00, 1'b0, 1'b0, "R3");

      // R4 with identity A and mixed-sign B
      fill_random();
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) ma[i][j] = (i == j) ? 16'sd1 : 16'sd0;
      run_job(2'b01, 1'b1, 1'b1, "R4");

      // R5 with extreme signed operands
      for (int i = 0; i < N; i++)
         for (int j = 0; j < N; j++) begin
            ma[i][j] = ((i + j) % 2 == 0) ? 16'sh7fff : 16'sh8000;
            mb[i][j] = ((i * j) % 3 == 0) ? 16'sh8001 : 16'sh7ffe;
            mc[i][j] = 32'(i * 16 + j);
         end
      run_job(2'b10, 1'b0, 1'b0, "R5");

      report();
   end

endmodule